// File: doc/BRIEF.md
# Add-With-Carry Execution Unit

This block executes the six opcodes of an 8-bit add-with-carry instruction family against a private 256-byte register file. The surrounding sequencer has already fetched the opcode and up to two operand bytes. It presents them together with a start pulse. The unit then resolves the destination and source operands, adds source, destination and the stored carry flag, writes the sum back to the destination and updates a six-bit flag register. After the number of cycles that the addressing mode requires, it raises a one-cycle completion pulse.

Short operand numbers (working registers, 0..15) are placed in the register file by a 4-bit pointer input. The pointer supplies the upper address nibble. An 8-bit register address whose upper nibble is 0xE is also treated as a working-register reference. A load port and a flag-load port preload state while the unit is idle. A combinational read port observes any register.

Top module: `adc_exec_unit`

## Requirements
- R1: On completion, the destination register holds (destination + source + stored carry) mod 256. The source location keeps its value.
- R2: Opcodes 0x12..0x17 select these destination/source modes: 0x12 working/working, 0x13 working/indirect working, 0x14 register/register, 0x15 register/indirect register, 0x16 register/immediate, 0x17 indirect register/immediate. For 0x14 and 0x15, oper_a_i is the source and oper_b_i is the destination. For 0x16 and 0x17, oper_a_i is the destination and oper_b_i is the immediate.
- R3: In 0x12 and 0x13, oper_a_i[7:4] names the destination working register and oper_a_i[3:0] names the source. Working register n lives at register-file address {rp_i, n}.
- R4: An 8-bit register address with upper nibble 0xE refers to address {rp_i, low nibble}. Any other 8-bit address is used as is.
- R5: For an indirect operand, the content of the named register is the effective 8-bit address, and this address is not remapped.
- R6: busy_o is high for exactly 6 cycles for 0x12/0x13 and exactly 10 cycles for 0x14..0x17, counted from the clock edge that accepts start_i. done_o rises in the cycle after the last busy cycle.
- R7: flags_o is {C,Z,S,V,D,H} from bit 5 down to bit 0. C is the carry out of bit 7, Z is set when the result is 0x00, and S is result bit 7.
- R8: V is set only when both addends have equal sign bits and the result sign differs. H is the carry out of bit 3, including the carry-in. D is cleared by every completed instruction.
- R9: start_i is ignored while busy_o is high. It is also ignored when opcode_i is outside 0x12..0x17: no busy, no done, and no register change.
- R10: done_o is high for one cycle only. The result write and the flag update become visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears flags and register file |
| start_i | input | 1 | Start request, sampled only when idle |
| opcode_i | input | 8 | Instruction opcode |
| oper_a_i | input | 8 | First operand byte |
| oper_b_i | input | 8 | Second operand byte |
| rp_i | input | 4 | Working-register pointer (upper address nibble) |
| ld_we_i | input | 1 | Register preload write enable (idle only) |
| ld_addr_i | input | 8 | Preload address |
| ld_data_i | input | 8 | Preload data |
| flag_we_i | input | 1 | Flag register load enable (idle only) |
| flag_i | input | 6 | Flag load value, {C,Z,S,V,D,H} |
| rd_addr_i | input | 8 | Observation read address |
| rd_data_o | output | 8 | Register content at rd_addr_i (combinational) |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 6 | Flag register, {C,Z,S,V,D,H} |

## Verification
All results land together. The destination byte and flags_o change on the clock edge that ends the last busy cycle. That edge comes 6 or 10 edges after the edge that accepts start_i, and done_o is high during the following cycle. The bench drives start_i on a falling edge and then counts the falling edges at which busy_o reads high. It requires that count to equal the mode's cycle count, and that done_o is high at the next falling edge. At that same falling edge it reads back the destination, the source and the flags. One falling edge later it confirms that done_o has dropped.

// File: rtl/adc_pkg.sv
package adc_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = 4;

    localparam logic [NIB_W-1:0] WR_ESCAPE = 4'hE;

    localparam logic [BYTE_W-1:0] OPC_WW  = 8'h12;
    localparam logic [BYTE_W-1:0] OPC_WI  = 8'h13;
    localparam logic [BYTE_W-1:0] OPC_RR  = 8'h14;
    localparam logic [BYTE_W-1:0] OPC_RI  = 8'h15;
    localparam logic [BYTE_W-1:0] OPC_RM  = 8'h16;
    localparam logic [BYTE_W-1:0] OPC_IM  = 8'h17;

    // Bit 5 down to bit 0: carry, zero, sign, overflow, decimal, half carry
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic d;
        logic h;
    } adc_flags_t;

    typedef struct packed {
        logic              valid;
        logic              long_form;
        logic [BYTE_W-1:0] dst_ptr;
        logic              dst_ind;
        logic [BYTE_W-1:0] src_ptr;
        logic              src_ind;
        logic              src_imm;
        logic [BYTE_W-1:0] imm;
    } adc_ops_t;

endpackage

// File: rtl/adc_decode.sv
module adc_decode
    import adc_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode_i,
    input  logic [BYTE_W-1:0] oper_a_i,
    input  logic [BYTE_W-1:0] oper_b_i,
    input  logic [NIB_W-1:0]  rp_i,
    output adc_ops_t          ops_o
);

    logic [BYTE_W-1:0] map_a;
    logic [BYTE_W-1:0] map_b;

    // 8-bit register address: escape nibble redirects into the working bank
    assign map_a = (oper_a_i[BYTE_W-1:NIB_W] == WR_ESCAPE) ? {rp_i, oper_a_i[NIB_W-1:0]} : oper_a_i;
    assign map_b = (oper_b_i[BYTE_W-1:NIB_W] == WR_ESCAPE) ? {rp_i, oper_b_i[NIB_W-1:0]} : oper_b_i;

    always_comb begin
        ops_o = '0;
        unique case (opcode_i)
            OPC_WW, OPC_WI: begin
                ops_o.valid   = 1'b1;
                ops_o.dst_ptr = {rp_i, oper_a_i[BYTE_W-1:NIB_W]};
                ops_o.src_ptr = {rp_i, oper_a_i[NIB_W-1:0]};
                ops_o.src_ind = (opcode_i == OPC_WI);
            end
            OPC_RR, OPC_RI: begin
                ops_o.valid     = 1'b1;
                ops_o.long_form = 1'b1;
                ops_o.src_ptr   = map_a;
                ops_o.dst_ptr   = map_b;
                ops_o.src_ind   = (opcode_i == OPC_RI);
            end
            OPC_RM, OPC_IM: begin
                ops_o.valid     = 1'b1;
                ops_o.long_form = 1'b1;
                ops_o.dst_ptr   = map_a;
                ops_o.dst_ind   = (opcode_i == OPC_IM);
                ops_o.src_imm   = 1'b1;
                ops_o.imm       = oper_b_i;
            end
            default: ops_o = '0;
        endcase
    end

endmodule

// File: rtl/adc_alu.sv
module adc_alu
    import adc_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output adc_flags_t   flags_o
);

    localparam int unsigned HB = W / 2;

    logic [W:0]  full;
    logic [HB:0] low;

    assign full  = {1'b0, dst_i} + {1'b0, src_i} + {{W{1'b0}}, cin_i};
    assign low   = {1'b0, dst_i[HB-1:0]} + {1'b0, src_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
    assign sum_o = full[W-1:0];

    always_comb begin
        flags_o.c = full[W];
        flags_o.z = (full[W-1:0] == '0);
        flags_o.s = full[W-1];
        flags_o.v = (dst_i[W-1] == src_i[W-1]) && (full[W-1] != dst_i[W-1]);
        flags_o.d = 1'b0;
        flags_o.h = low[HB];
    end

endmodule

// File: rtl/adc_regfile.sv
module adc_regfile #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_RD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i [N_RD],
    output logic [DATA_W-1:0] rdata_o [N_RD]
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rdata_o[g] = mem_q[raddr_i[g]];
    end

endmodule

// File: rtl/adc_exec_unit.sv
module adc_exec_unit
    import adc_pkg::*;
#(
    parameter int unsigned CYC_SHORT = 6,
    parameter int unsigned CYC_LONG  = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  opcode_i,
    input  logic [7:0]  oper_a_i,
    input  logic [7:0]  oper_b_i,
    input  logic [3:0]  rp_i,
    input  logic        ld_we_i,
    input  logic [7:0]  ld_addr_i,
    input  logic [7:0]  ld_data_i,
    input  logic        flag_we_i,
    input  logic [5:0]  flag_i,
    input  logic [7:0]  rd_addr_i,
    output logic [7:0]  rd_data_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [5:0]  flags_o
);

    localparam int unsigned CW      = $clog2(CYC_LONG + 1);
    localparam int unsigned N_RD    = 3;
    localparam int unsigned P_DST   = 0;
    localparam int unsigned P_SRC   = 1;
    localparam int unsigned P_HOST  = 2;

    typedef struct packed {
        logic       busy;
        logic       done;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        adc_ops_t   ops;
        adc_flags_t flags;
    } exec_st_t;

    exec_st_t st_d, st_q;

    adc_ops_t          dec_ops;
    logic [BYTE_W-1:0] raddr [N_RD];
    logic [BYTE_W-1:0] rdata [N_RD];
    logic [BYTE_W-1:0] src_val;
    logic [BYTE_W-1:0] alu_sum;
    adc_flags_t        alu_flags;
    logic              wb_en;
    logic              rf_we;
    logic [BYTE_W-1:0] rf_waddr;
    logic [BYTE_W-1:0] rf_wdata;

    adc_decode i_decode (
        .opcode_i (opcode_i),
        .oper_a_i (oper_a_i),
        .oper_b_i (oper_b_i),
        .rp_i     (rp_i),
        .ops_o    (dec_ops)
    );

    // Pointer fields double as effective addresses once indirection is resolved
    assign raddr[P_DST]  = st_q.ops.dst_ptr;
    assign raddr[P_SRC]  = st_q.ops.src_ptr;
    assign raddr[P_HOST] = rd_addr_i;

    adc_regfile #(
        .ADDR_W (BYTE_W),
        .DATA_W (BYTE_W),
        .N_RD   (N_RD)
    ) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    assign src_val = st_q.ops.src_imm ? st_q.ops.imm : rdata[P_SRC];

    adc_alu #(
        .W (BYTE_W)
    ) i_alu (
        .dst_i   (rdata[P_DST]),
        .src_i   (src_val),
        .cin_i   (st_q.flags.c),
        .sum_o   (alu_sum),
        .flags_o (alu_flags)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wb_en     = 1'b0;
        if (!st_q.busy) begin
            if (flag_we_i) st_d.flags = adc_flags_t'(flag_i);
            if (start_i && dec_ops.valid) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.lim  = dec_ops.long_form ? CW'(CYC_LONG) : CW'(CYC_SHORT);
                st_d.ops  = dec_ops;
            end
        end else begin
            if (st_q.cnt == '0) begin
                if (st_q.ops.dst_ind) st_d.ops.dst_ptr = rdata[P_DST];
                if (st_q.ops.src_ind) st_d.ops.src_ptr = rdata[P_SRC];
                st_d.ops.dst_ind = 1'b0;
                st_d.ops.src_ind = 1'b0;
            end
            if (st_q.cnt == st_q.lim - CW'(1)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.flags = alu_flags;
                wb_en      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    assign rf_we    = wb_en || (ld_we_i && !st_q.busy);
    assign rf_waddr = wb_en ? st_q.ops.dst_ptr : ld_addr_i;
    assign rf_wdata = wb_en ? alu_sum : ld_data_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign flags_o   = st_q.flags;
    assign rd_data_o = rdata[P_HOST];

endmodule

// File: rtl/adc_exec_checker.sv
module adc_exec_checker #(
    parameter int unsigned CYC_SHORT = 6,
    parameter int unsigned CYC_LONG  = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [7:0] opcode_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [5:0] flags_o
);

    logic        known_op;
    logic [15:0] cyc_q;
    logic [15:0] exp_q;

    assign known_op = (opcode_i >= 8'h12) && (opcode_i <= 8'h17);

    // Window counter: busy cycles since the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            exp_q <= '0;
        end else if (!busy_o && start_i && known_op) begin
            cyc_q <= '0;
            exp_q <= (opcode_i <= 8'h13) ? 16'(CYC_SHORT) : 16'(CYC_LONG);
        end else if (busy_o) begin
            cyc_q <= cyc_q + 16'd1;
        end
    end

    p_cycle_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_q == exp_q));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_dflag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !flags_o[1]);

    p_bad_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !known_op) |=> !busy_o);

    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind adc_exec_unit adc_exec_checker #(
    .CYC_SHORT (CYC_SHORT),
    .CYC_LONG  (CYC_LONG)
) i_adc_exec_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .flags_o  (flags_o)
);

// File: tb/test_adc_exec_unit.sv
`timescale 1ns/1ps
module test_adc_exec_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opcode_i = '0;
    logic [7:0] oper_a_i = '0;
    logic [7:0] oper_b_i = '0;
    logic [3:0] rp_i = '0;
    logic       ld_we_i = 1'b0;
    logic [7:0] ld_addr_i = '0;
    logic [7:0] ld_data_i = '0;
    logic       flag_we_i = 1'b0;
    logic [5:0] flag_i = '0;
    logic [7:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       busy_o;
    logic       done_o;
    logic [5:0] flags_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_exec_unit i_adc_exec_unit (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr_i = a;
        #0.5;
        d = rd_data_o;
    endtask

    task automatic load(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_we_i = 1'b1; ld_addr_i = a; ld_data_i = d;
        @(negedge clk);
        ld_we_i = 1'b0;
    endtask

    // Preload destination and flag register in the same cycle
    task automatic load_with_flags(input logic [7:0] a, input logic [7:0] d, input logic [5:0] f);
        @(negedge clk);
        ld_we_i = 1'b1; ld_addr_i = a; ld_data_i = d;
        flag_we_i = 1'b1; flag_i = f;
        @(negedge clk);
        ld_we_i = 1'b0; flag_we_i = 1'b0;
    endtask

    function automatic logic [5:0] exp_flags(input int d, input int s, input int c);
        int sum, res;
        logic fc, fz, fs, fv, fh;
        sum = d + s + c;
        res = sum % 256;
        fc  = (sum > 255);
        fz  = (res == 0);
        fs  = (res >= 128);
        fv  = ((d >= 128) == (s >= 128)) && ((res >= 128) != (d >= 128));
        fh  = (((d % 16) + (s % 16) + c) > 15);
        return {fc, fz, fs, fv, 1'b0, fh};
    endfunction

    // Issue one instruction, measure busy length, check result and flags on the done cycle
    task automatic run(input logic [7:0] opc, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] dst_addr, input int d, input int s, input int c,
                       input int cycles);
        int n;
        logic [7:0] got;
        logic [5:0] ef;
        n = 0;
        start_i = 1'b1; opcode_i = opc; oper_a_i = a; oper_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && n < 40) begin
            n++;
            @(negedge clk);
        end
        chk(n == cycles, "R6 busy cycles", n, cycles);
        chk(done_o == 1'b1, "R10 done after busy", done_o, 1);
        rd(dst_addr, got);
        chk(got == 8'((d + s + c) % 256), "R1 sum written", got, (d + s + c) % 256);
        ef = exp_flags(d, s, c);
        chk(flags_o[5:3] == ef[5:3], "R7 C/Z/S flags", flags_o, ef);
        chk(flags_o[2:0] == ef[2:0], "R8 V/D/H flags", flags_o, ef);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(busy_o == 1'b0, "R6 reset busy", busy_o, 0);
        chk(done_o == 1'b0, "R10 reset done", done_o, 0);
        chk(flags_o == 6'h00, "R7 reset flags", flags_o, 0);
        rd(8'h40, v);
        chk(v == 8'h00, "R1 reset register", v, 0);

        // R3 R2: working/working, 0x12 0x3B with pointer 3 -> dst 0x33, src 0x3B
        rp_i = 4'h3;
        load(8'h3B, 8'h20);
        load_with_flags(8'h33, 8'h16, 6'b100000);
        run(8'h12, 8'h3B, 8'h00, 8'h33, 'h16, 'h20, 1, 6);
        chk(flags_o == 6'h00, "R7 example all flags clear", flags_o, 0);
        rd(8'h3B, v);
        chk(v == 8'h20, "R1 source unchanged 0x12", v, 8'h20);

        // R5 R3: working/indirect working, 0x13 0x5A, pointer 2 -> dst 0x25, pointer reg 0x2A -> 0x80
        rp_i = 4'h2;
        load(8'h2A, 8'h80);
        load(8'h80, 8'h01);
        load_with_flags(8'h25, 8'h7F, 6'b011111);
        run(8'h13, 8'h5A, 8'h00, 8'h25, 'h7F, 'h01, 0, 6);
        rd(8'h80, v);
        chk(v == 8'h01, "R5 indirect source unchanged", v, 8'h01);
        rd(8'h2A, v);
        chk(v == 8'h80, "R5 pointer register unchanged", v, 8'h80);

        // R4 R2: reg/reg 0x14, src 0xE7 escapes to 0xC7, dst 0x40
        rp_i = 4'hC;
        load(8'hC7, 8'hFF);
        load_with_flags(8'h40, 8'h01, 6'b000000);
        run(8'h14, 8'hE7, 8'h40, 8'h40, 'h01, 'hFF, 0, 10);
        rd(8'hE7, v);
        chk(v == 8'h00, "R4 escaped address not used literally", v, 0);

        // R5 R4: reg/indirect reg 0x15, src via 0x41 -> 0x90, dst 0xE1 -> 0xC1
        load(8'h41, 8'h90);
        load(8'h90, 8'h35);
        load_with_flags(8'hC1, 8'h10, 6'b100000);
        run(8'h15, 8'h41, 8'hE1, 8'hC1, 'h10, 'h35, 1, 10);

        // R5 R2: indirect reg/immediate 0x17, dst via 0xE2 -> 0x52 -> 0xA0 (no remap of 0xA0)
        rp_i = 4'h5;
        load(8'h52, 8'hA0);
        load_with_flags(8'hA0, 8'h80, 6'b000000);
        run(8'h17, 8'hE2, 8'h80, 8'hA0, 'h80, 'h80, 0, 10);
        rd(8'h52, v);
        chk(v == 8'hA0, "R5 pointer register keeps value", v, 8'hA0);

        // R9: unsupported opcode is ignored
        load_with_flags(8'h40, 8'h55, 6'b100000);
        start_i = 1'b1; opcode_i = 8'h18; oper_a_i = 8'h40; oper_b_i = 8'h01;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 12; k++) begin
            chk(busy_o == 1'b0 && done_o == 1'b0, "R9 bad opcode no activity", {busy_o, done_o}, 0);
            @(negedge clk);
        end
        rd(8'h40, v);
        chk(v == 8'h55, "R9 bad opcode register unchanged", v, 8'h55);
        chk(flags_o == 6'b100000, "R9 bad opcode flags unchanged", flags_o, 6'b100000);

        // R9: start during busy is ignored (second request targets 0x33)
        rp_i = 4'h3;
        load(8'h33, 8'h11);
        load_with_flags(8'h40, 8'h02, 6'b000000);
        begin
            int n;
            n = 0;
            start_i = 1'b1; opcode_i = 8'h16; oper_a_i = 8'h40; oper_b_i = 8'h03;
            @(negedge clk);
            start_i = 1'b0;
            while (busy_o && n < 40) begin
                n++;
                if (n == 3) begin
                    start_i = 1'b1; opcode_i = 8'h12; oper_a_i = 8'h3B;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            chk(n == 10, "R9 busy length unaffected by start", n, 10);
            rd(8'h40, v);
            chk(v == 8'h05, "R9 first instruction result", v, 8'h05);
            @(negedge clk);
            chk(busy_o == 1'b0, "R9 no second instruction started", busy_o, 0);
            rd(8'h33, v);
            chk(v == 8'h11, "R9 ignored target unchanged", v, 8'h11);
        end

        // Near-exhaustive sweep: reg/immediate, every destination, 16 sources, both carries
        rp_i = 4'h0;
        for (int d = 0; d < 256; d++) begin
            for (int k = 0; k < 16; k++) begin
                for (int c = 0; c < 2; c++) begin
                    int s;
                    s = (k * 17) ^ ((k & 3) << 6);
                    load_with_flags(8'h40, 8'(d), {1'(c), 5'b11111});
                    run(8'h16, 8'h40, 8'(s), 8'h40, d, s, c, 10);
                end
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule